// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block works next to a small 8-bit processor core and handles the entry into interrupts and the return from them. At each instruction boundary it looks at the pending request flags, the per-source enable masks and the global enable flag. If it takes an interrupt, it picks the enabled source with the lowest index. It then saves the 16-bit program counter on a byte-wide stack in data memory, clears the global enable flag and the chosen request flag, and sends fetch to that source's vector. The whole entry takes four clock cycles.

When the core decodes a return-from-interrupt, the block reads the two saved bytes back from the stack. It restores the program counter, moves the stack pointer back up by two and sets the global enable flag again, also in four clock cycles. After a return, the block lets exactly one main-program instruction run before it will accept another pending request.

The core stalls on `busy` while a sequence is running. The core keeps ownership of the stack pointer and the status flag, and it applies the `sp_we`, `gie_clr` and `gie_set` strobes that the block produces. Stack memory reads are synchronous, with one cycle of latency.

Top module: `irq_seq`

## Requirements
- R1: While reset is held and right after it, `busy`, `irq_ack`, `mem_we`, `mem_re`, `vec_valid`, `pc_load`, `sp_we`, `gie_clr` and `gie_set` are all 0.
- R2: An interrupt is accepted only in a cycle where `busy` is 0, `insn_done` is 1, `gie` is 1 and `irq_flags & irq_mask` is nonzero. A request that is pending during the cycles of a multi-cycle instruction (no `insn_done`) is not taken until the boundary arrives.
- R3: Call the accepting cycle T. `busy` is 1 in cycles T+1 to T+4. `vec_valid` pulses in T+4 with `vec_addr = VEC_BASE + index*VEC_STRIDE`, which is index+1 with the default parameters. `busy` is 0 again in T+5.
- R4: The PC and SP are taken from `pc_in` and `sp_in` in cycle T. In T+1 the block writes PC[7:0] to address SP. In T+2 it writes PC[15:8] to address SP-1. In T+4 `sp_we` pulses with `sp_wdata` = SP-2.
- R5: When several enabled sources are pending, the one with the lowest bit index wins. In T+1, `irq_ack` carries a one-hot pulse on that bit alone, and `gie_clr` pulses.
- R6: A `reti_strobe` in an idle cycle R starts a return, and it takes priority over a simultaneous `insn_done`. The SP is taken from `sp_in` in R. In R+1 the block reads address SP+1, which holds the high byte. In R+2 it reads address SP+2, which holds the low byte. In R+4, `pc_load` pulses with `pc_out` = {high, low}, `sp_we` pulses with `sp_wdata` = SP+2, and `gie_set` pulses.
- R7: After a return, the first `insn_done` takes no interrupt even if an enabled request is pending. A later `insn_done` can take one.
- R8: `insn_done` and `reti_strobe` have no effect while `busy` is 1.
- R9: `mem_we` and `mem_re` are never 1 in the same cycle. `vec_valid` and `pc_load` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary: the core can insert an interrupt before its next instruction |
| reti_strobe | input | 1 | Core decoded a return-from-interrupt |
| gie | input | 1 | Current global interrupt enable flag |
| irq_flags | input | NSRC | Pending request flags |
| irq_mask | input | NSRC | Per-source enable bits |
| pc_in | input | PC_W | Program counter to save on entry |
| sp_in | input | SP_W | Current stack pointer |
| busy | output | 1 | Sequence running; the core stalls |
| irq_ack | output | NSRC | One-hot clear pulse for the winning flag |
| gie_clr | output | 1 | Clear the global enable flag |
| gie_set | output | 1 | Set the global enable flag |
| vec_valid | output | 1 | Redirect fetch to `vec_addr` |
| vec_addr | output | PC_W | Vector address of the taken source |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | PC_W | Restored program counter |
| sp_we | output | 1 | Write `sp_wdata` into the stack pointer |
| sp_wdata | output | SP_W | New stack pointer value |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | SP_W | Stack memory address |
| mem_wdata | output | 8 | Stack write byte |
| mem_rdata | input | 8 | Stack read byte, valid the cycle after `mem_re` |

## Verification
The hardest situation to reach is the single-instruction hold after a return. It only appears when an enabled request is already pending at the first boundary that follows `pc_load`. The bench first takes an interrupt so that real bytes are on the stack. It then returns with `gie` and the request still driven high, raises `insn_done` right after the return and checks that `busy` stays low. Only on the second boundary does it expect the entry to begin. A second hard case is a strobe arriving while the block is busy. The bench holds `reti_strobe` and `insn_done` high through an entry and checks that no read and no re-entry follows.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   // Sequencer states: four entry steps, four return steps
   typedef enum logic [3:0] {
      ST_IDLE    = 4'd0,
      ST_ENT_LO  = 4'd1,
      ST_ENT_HI  = 4'd2,
      ST_ENT_GAP = 4'd3,
      ST_ENT_VEC = 4'd4,
      ST_RET_HI  = 4'd5,
      ST_RET_LO  = 4'd6,
      ST_RET_CAP = 4'd7,
      ST_RET_LD  = 4'd8
   } seq_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NSRC    = 8,
   parameter int IDX_W   = 3,
   parameter bit ISOLATE = 1'b1
) (
   input  logic [NSRC-1:0]  req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   assign any = |req;

   generate
      if (ISOLATE) begin : g_iso
         // keep only the lowest set bit, then encode it
         logic [NSRC-1:0] lowest;
         assign lowest = req & (~req + {{(NSRC-1){1'b0}}, 1'b1});
         always_comb begin
            idx = '0;
            for (int i = 0; i < NSRC; i++) begin
               if (lowest[i]) idx = idx | IDX_W'(i);
            end
         end
      end else begin : g_scan
         // downward scan: the last hit is the lowest index
         always_comb begin
            idx = '0;
            for (int i = NSRC - 1; i >= 0; i--) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
   parameter int NSRC       = 8,
   parameter int IDX_W      = 3,
   parameter int PC_W       = 16,
   parameter int VEC_BASE   = 1,
   parameter int VEC_STRIDE = 1
) (
   input  logic [IDX_W-1:0] idx,
   output logic [PC_W-1:0]  addr
);

   localparam int SHIFT = $clog2(VEC_STRIDE);

   generate
      if (irq_seq_pkg::is_pow2(VEC_STRIDE)) begin : g_shift
         assign addr = PC_W'(VEC_BASE) + (PC_W'(idx) << SHIFT);
      end else begin : g_mul
         assign addr = PC_W'(VEC_BASE) + PC_W'(idx) * PC_W'(VEC_STRIDE);
      end
      if (NSRC < 1) begin : g_bad_nsrc
         $error("irq_vec_map: NSRC must be positive");
      end
   endgenerate

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
   import irq_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       boundary,
   input  logic       take_req,
   input  logic       ret_req,
   output seq_state_e state,
   output logic       start_take,
   output logic       start_ret
);

   seq_state_e nxt;
   logic       skip_q;   // one main instruction owed after a return

   always_comb begin
      nxt        = state;
      start_take = 1'b0;
      start_ret  = 1'b0;
      case (state)
         ST_IDLE: begin
            if (ret_req) begin
               nxt       = ST_RET_HI;
               start_ret = 1'b1;
            end else if (boundary && !skip_q && take_req) begin
               nxt        = ST_ENT_LO;
               start_take = 1'b1;
            end
         end
         ST_ENT_LO:  nxt = ST_ENT_HI;
         ST_ENT_HI:  nxt = ST_ENT_GAP;
         ST_ENT_GAP: nxt = ST_ENT_VEC;
         ST_ENT_VEC: nxt = ST_IDLE;
         ST_RET_HI:  nxt = ST_RET_LO;
         ST_RET_LO:  nxt = ST_RET_CAP;
         ST_RET_CAP: nxt = ST_RET_LD;
         ST_RET_LD:  nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         skip_q <= 1'b0;
      end else begin
         state <= nxt;
         if (state == ST_RET_LD)
            skip_q <= 1'b1;
         else if (state == ST_IDLE && boundary && !ret_req)
            skip_q <= 1'b0;
      end
   end

   // R7: the first boundary after a return never starts an entry
   p_skip_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && skip_q && boundary && !ret_req) |=> (state == ST_IDLE));

   // R8: a running sequence is not cut short by strobes
   p_no_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_ENT_VEC && state != ST_RET_LD) |=> (state != ST_IDLE));

endmodule

// File: rtl/irq_stack_port.sv
module irq_stack_port
   import irq_seq_pkg::*;
#(
   parameter int PC_W = 16,
   parameter int SP_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  seq_state_e      state,
   input  logic [SP_W-1:0] sp_base,
   input  logic [PC_W-1:0] pc_save,
   input  logic [7:0]      rdata,
   output logic            mem_we,
   output logic            mem_re,
   output logic [SP_W-1:0] mem_addr,
   output logic [7:0]      mem_wdata,
   output logic [PC_W-1:0] pc_rest,
   output logic [SP_W-1:0] sp_next
);

   localparam int HI_W = PC_W - 8;

   logic [7:0] hi_q;
   logic [7:0] lo_q;

   always_comb begin
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_addr  = sp_base;
      mem_wdata = 8'h00;
      sp_next   = sp_base;
      case (state)
         ST_ENT_LO: begin
            mem_we    = 1'b1;
            mem_wdata = pc_save[7:0];
         end
         ST_ENT_HI: begin
            mem_we    = 1'b1;
            mem_addr  = sp_base - SP_W'(1);
            mem_wdata = 8'(pc_save[PC_W-1:8]);
         end
         ST_ENT_VEC: sp_next = sp_base - SP_W'(2);
         ST_RET_HI: begin
            mem_re   = 1'b1;
            mem_addr = sp_base + SP_W'(1);
         end
         ST_RET_LO: begin
            mem_re   = 1'b1;
            mem_addr = sp_base + SP_W'(2);
         end
         ST_RET_LD: sp_next = sp_base + SP_W'(2);
         default: ;
      endcase
   end

   // read data arrives one cycle after its strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= 8'h00;
         lo_q <= 8'h00;
      end else begin
         if (state == ST_RET_LO)  hi_q <= rdata;
         if (state == ST_RET_CAP) lo_q <= rdata;
      end
   end

   assign pc_rest = {hi_q[HI_W-1:0], lo_q};

   // R4: the high byte goes one address below the low byte, in the next cycle
   p_push_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && state == ST_ENT_LO) |=> (mem_we && mem_addr == $past(mem_addr) - SP_W'(1)));

   // R6: the low-byte read follows the high-byte read one address up
   p_pop_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re && state == ST_RET_HI) |=> (mem_re && mem_addr == $past(mem_addr) + SP_W'(1)));

endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_seq_pkg::*;
#(
   parameter int NSRC       = 8,
   parameter int PC_W       = 16,
   parameter int SP_W       = 16,
   parameter int VEC_BASE   = 1,
   parameter int VEC_STRIDE = 1,
   parameter bit ISOLATE    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            insn_done,
   input  logic            reti_strobe,
   input  logic            gie,
   input  logic [NSRC-1:0] irq_flags,
   input  logic [NSRC-1:0] irq_mask,
   input  logic [PC_W-1:0] pc_in,
   input  logic [SP_W-1:0] sp_in,
   output logic            busy,
   output logic [NSRC-1:0] irq_ack,
   output logic            gie_clr,
   output logic            gie_set,
   output logic            vec_valid,
   output logic [PC_W-1:0] vec_addr,
   output logic            pc_load,
   output logic [PC_W-1:0] pc_out,
   output logic            sp_we,
   output logic [SP_W-1:0] sp_wdata,
   output logic            mem_we,
   output logic            mem_re,
   output logic [SP_W-1:0] mem_addr,
   output logic [7:0]      mem_wdata,
   input  logic [7:0]      mem_rdata
);

   localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   generate
      if (NSRC < 1 || NSRC > 32) begin : g_chk_nsrc
         $error("irq_seq: NSRC out of range 1..32");
      end
      if (PC_W < 9 || PC_W > 16) begin : g_chk_pc
         $error("irq_seq: PC_W must fit in two bytes");
      end
      if (SP_W < 8) begin : g_chk_sp
         $error("irq_seq: SP_W too narrow");
      end
      if (VEC_STRIDE < 1) begin : g_chk_stride
         $error("irq_seq: VEC_STRIDE must be positive");
      end
   endgenerate

   logic [NSRC-1:0]  enabled;
   logic             any_req;
   logic [IDX_W-1:0] pick_idx;
   seq_state_e       state;
   logic             start_take;
   logic             start_ret;
   logic [IDX_W-1:0] win_idx_q;
   logic [PC_W-1:0]  pc_save_q;
   logic [SP_W-1:0]  sp_save_q;

   assign enabled = irq_flags & irq_mask;

   irq_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W), .ISOLATE(ISOLATE)) u_pick (
      .req (enabled),
      .any (any_req),
      .idx (pick_idx)
   );

   irq_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .boundary   (insn_done),
      .take_req   (gie && any_req),
      .ret_req    (reti_strobe),
      .state      (state),
      .start_take (start_take),
      .start_ret  (start_ret)
   );

   // capture context at the accepting boundary
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_idx_q <= '0;
         pc_save_q <= '0;
         sp_save_q <= '0;
      end else if (start_take) begin
         win_idx_q <= pick_idx;
         pc_save_q <= pc_in;
         sp_save_q <= sp_in;
      end else if (start_ret) begin
         sp_save_q <= sp_in;
      end
   end

   irq_stack_port #(.PC_W(PC_W), .SP_W(SP_W)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .sp_base   (sp_save_q),
      .pc_save   (pc_save_q),
      .rdata     (mem_rdata),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .pc_rest   (pc_out),
      .sp_next   (sp_wdata)
   );

   irq_vec_map #(
      .NSRC(NSRC), .IDX_W(IDX_W), .PC_W(PC_W),
      .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
   ) u_vec (
      .idx  (win_idx_q),
      .addr (vec_addr)
   );

   assign busy      = (state != ST_IDLE);
   assign irq_ack   = (state == ST_ENT_LO) ? (NSRC'(1) << win_idx_q) : '0;
   assign gie_clr   = (state == ST_ENT_LO);
   assign vec_valid = (state == ST_ENT_VEC);
   assign pc_load   = (state == ST_RET_LD);
   assign gie_set   = (state == ST_RET_LD);
   assign sp_we     = (state == ST_ENT_VEC) || (state == ST_RET_LD);

   // R2: an acknowledge implies enable and boundary one cycle before
   p_ack_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack != '0) |-> ($past(gie) && $past(insn_done)));

   // R5: the acknowledged bit was enabled and no lower one was
   p_ack_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack != '0) |-> (((irq_ack & $past(enabled)) == irq_ack) &&
                           (($past(enabled) & (irq_ack - NSRC'(1))) == '0)));

   p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));

   // R3: vector redirect three cycles after the acknowledge
   p_entry_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack != '0) |-> ##3 (vec_valid && sp_we));

   // R6: restore completes three cycles after the first stack read
   p_ret_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re && !$past(busy)) |-> ##3 (pc_load && gie_set && sp_we));

   // R9: exclusive memory strobes and single-cycle pulses
   p_rw_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   p_vec_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !vec_valid);

   p_load_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !pc_load);

endmodule

// File: tb/tb_irq_seq.sv
`timescale 1ns/1ps
module tb_irq_seq;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        insn_done, reti_strobe, gie;
   logic [7:0]  irq_flags, irq_mask;
   logic [15:0] pc_in, sp_in;
   logic        busy, gie_clr, gie_set, vec_valid, pc_load, sp_we, mem_we, mem_re;
   logic [7:0]  irq_ack, mem_wdata, mem_rdata;
   logic [15:0] vec_addr, pc_out, sp_wdata, mem_addr;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [20:0] e;

   always #4 clk = ~clk;

   irq_seq dut (
      .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .reti_strobe(reti_strobe),
      .gie(gie), .irq_flags(irq_flags), .irq_mask(irq_mask), .pc_in(pc_in),
      .sp_in(sp_in), .busy(busy), .irq_ack(irq_ack), .gie_clr(gie_clr),
      .gie_set(gie_set), .vec_valid(vec_valid), .vec_addr(vec_addr),
      .pc_load(pc_load), .pc_out(pc_out), .sp_we(sp_we), .sp_wdata(sp_wdata),
      .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // stack memory with one-cycle read latency
   logic [7:0] mem [0:255];
   always_ff @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
   end

   // {flags, mask, gie, accept, winner index}
   localparam logic [20:0] TAB [0:7] = '{
      {8'h01, 8'h01, 1'b1, 1'b1, 3'd0},
      {8'h0C, 8'hFF, 1'b1, 1'b1, 3'd2},
      {8'hFF, 8'h00, 1'b1, 1'b0, 3'd0},
      {8'hF0, 8'hA0, 1'b1, 1'b1, 3'd5},
      {8'h80, 8'h80, 1'b0, 1'b0, 3'd0},
      {8'h80, 8'h80, 1'b1, 1'b1, 3'd7},
      {8'h00, 8'hFF, 1'b1, 1'b0, 3'd0},
      {8'h06, 8'h04, 1'b1, 1'b1, 3'd2}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // caller has driven insn_done=1 with an enabled request pending
   task automatic do_take(input logic [15:0] pc, input logic [15:0] sp, input int idx);
      step();
      insn_done = 1'b0;
      chk("R5 ack", 32'(irq_ack), 32'(8'(1) << idx));
      chk("R5 gie_clr", 32'(gie_clr), 32'd1);
      chk("R4 push lo", {15'd0, mem_we, mem_addr}, {15'd1, sp});
      chk("R4 lo byte", 32'(mem_wdata), 32'(pc[7:0]));
      step();
      chk("R4 push hi", {15'd0, mem_we, mem_addr}, {15'd1, sp - 16'd1});
      chk("R4 hi byte", 32'(mem_wdata), 32'(pc[15:8]));
      step();
      chk("R3 gap", {busy, mem_we, mem_re, vec_valid}, 4'b1000);
      step();
      chk("R3 vector", {15'd0, vec_valid, vec_addr}, {15'd1, 16'(idx + 1)});
      chk("R4 sp down", {15'd0, sp_we, sp_wdata}, {15'd1, sp - 16'd2});
      chk("R9 excl", 32'(mem_we & mem_re), 32'd0);
      step();
      chk("R3 end", {busy, vec_valid}, 2'b00);
   endtask

   task automatic do_ret(input logic [15:0] sp, input logic [15:0] exp_pc, input logic with_bnd);
      reti_strobe = 1'b1;
      insn_done   = with_bnd;
      step();
      reti_strobe = 1'b0;
      insn_done   = 1'b0;
      chk("R6 rd hi", {15'd0, mem_re, mem_addr}, {15'd1, sp + 16'd1});
      chk("R6 no ent", 32'(irq_ack), 32'd0);
      step();
      chk("R6 rd lo", {15'd0, mem_re, mem_addr}, {15'd1, sp + 16'd2});
      step();
      chk("R6 wait", {busy, mem_re, pc_load}, 3'b100);
      step();
      chk("R6 pc", {15'd0, pc_load, pc_out}, {15'd1, exp_pc});
      chk("R6 sp up", {15'd0, sp_we, sp_wdata}, {15'd1, sp + 16'd2});
      chk("R6 gie_set", 32'(gie_set), 32'd1);
      step();
      chk("R9 pulse", {busy, pc_load}, 2'b00);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; insn_done = 1'b0; reti_strobe = 1'b0; gie = 1'b0;
      irq_flags = '0; irq_mask = '0; pc_in = '0; sp_in = 16'h00F0;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      step(); step();
      chk("R1 reset", {busy, mem_we, mem_re, vec_valid, pc_load, sp_we, gie_clr, gie_set}, 8'h00);
      chk("R1 ack", 32'(irq_ack), 32'd0);
      rst_n = 1'b1;
      step();
      chk("R1 after", {busy, mem_we, mem_re, vec_valid, pc_load, sp_we}, 6'h00);

      // table walk: R2 gating and R5 priority
      for (int i = 0; i < 8; i++) begin
         e = TAB[i];
         irq_flags = e[20:13];
         irq_mask  = e[12:5];
         gie       = e[4];
         pc_in     = 16'h1000 + 16'(i * 16'h0123);
         sp_in     = 16'h00F0 - 16'(i * 4);
         insn_done = 1'b1;
         if (e[3]) begin
            do_take(pc_in, sp_in, int'(e[2:0]));
         end else begin
            step();
            insn_done = 1'b0;
            chk("R2 refused", {busy, mem_we}, 2'b00);
            chk("R2 no ack", 32'(irq_ack), 32'd0);
         end
      end

      // R2: multi-cycle instruction delays the entry to its boundary
      irq_flags = 8'h10; irq_mask = 8'h10; gie = 1'b1;
      pc_in = 16'hBEEF; sp_in = 16'h0080;
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R2 mid-insn", 32'(busy), 32'd0);
      end
      insn_done = 1'b1;
      do_take(16'hBEEF, 16'h0080, 4);

      // R6 + R7: return with request still pending
      irq_flags = 8'h02; irq_mask = 8'h02; gie = 1'b1;
      pc_in = 16'h2345; sp_in = 16'h007E;
      do_ret(16'h007E, 16'hBEEF, 1'b1);
      insn_done = 1'b1;
      step();
      insn_done = 1'b0;
      chk("R7 held once", {busy, mem_we}, 2'b00);
      step();
      insn_done = 1'b1;
      sp_in = 16'h0060;
      do_take(16'h2345, 16'h0060, 1);

      // R8: strobes during an entry are ignored
      irq_flags = 8'h01; irq_mask = 8'h01; pc_in = 16'h0A0B; sp_in = 16'h0040;
      insn_done = 1'b1;
      step();
      chk("R8 start", 32'(busy), 32'd1);
      reti_strobe = 1'b1;
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R8 no read", {mem_re, busy}, 2'b01);
      end
      reti_strobe = 1'b0;
      insn_done = 1'b0;
      step();
      chk("R8 back idle", {busy, mem_re, irq_ack}, 10'h000);

      // R6: plain return pops the bytes just pushed
      sp_in = 16'h003E;
      do_ret(16'h003E, 16'h0A0B, 1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule